// File: doc/BRIEF.md
# Periodic / One-Shot Comparator Timer Channel

This block is one comparator channel that watches a shared 32-bit free-running count supplied from outside. It holds a deadline (the comparator value) and, in periodic mode, a period. When the count arrives at the deadline while counting is enabled, it emits a single-cycle fire strobe toward an interrupt router. The interrupt routing and the register decode live elsewhere. The owner of the count drives the count value, its enable, and a restart strobe whenever counting starts or the count is rewritten.

In one-shot mode the deadline is written directly, and nothing corrects a deadline that already lies behind the count. The channel then fires only after the count wraps. In periodic mode, a comparator write loads the period. The same write loads the deadline only while a self-clearing value-set flag is armed. On each periodic fire, on every restart, and on any write that changes the deadline or the period while counting, the channel recomputes the deadline as the first multiple of the period past the count. A sequential remainder divider does this work. Fire detection stays blocked until the new deadline is in place.

Top module: `tmr_channel`

## Requirements
- R1: After reset, cmp_o is 0xFFFFFFFF, rate_o is 0, valset_o is 0 and fire_o is 0.
- R2: fire_o is high for exactly one cycle, in the cycle after a cycle in which count_en_i is 1, count_i equals cmp_o, no deadline recomputation is in progress, and that equality did not already hold in the cycle before. A count held at the deadline fires once. With count_en_i at 0, no fire occurs.
- R3: In one-shot mode (periodic_i = 0), a comparator write sets cmp_o to (cmp_o & ~cmp_wmask_i) | (cmp_wdata_i & cmp_wmask_i) in the next cycle, and rate_o stays 0.
- R4: In periodic mode, a comparator write sets rate_o to (rate_o & ~cmp_wmask_i) | (cmp_wdata_i & cmp_wmask_i). cmp_o takes that same merged value only if valset_o was 1 before the write; otherwise cmp_o is unchanged.
- R5: A pulse on valset_set_i sets valset_o to 1. Any comparator write clears it in the next cycle.
- R6: While periodic_i is 0, rate_o reads 0 from the next cycle on.
- R7: In periodic mode with a nonzero rate, a fire at count C moves cmp_o to C + rate_o.
- R8: In periodic mode with a nonzero rate, a restart pulse with count C sets cmp_o to cmp + ((C - cmp) / rate + 1) * rate in 32-bit modular arithmetic, within 36 cycles, while C is held. This also holds across the 2^32 wrap.
- R9: A comparator write that changes the deadline or the period while count_en_i is 1 recomputes the deadline as in R8, using the count at the write. While count_en_i is 0, no recomputation occurs.
- R10: In one-shot mode, a deadline below the count is not corrected. The fire comes only when the count wraps around to it.
- R11: A fire that is due in the last enabled cycle is still delivered, even though count_en_i falls right after.
- R12: While a deadline recomputation is in progress, the count passing the old deadline produces no fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 32 | Shared main count value |
| count_en_i | input | 1 | Main count is running |
| restart_i | input | 1 | Strobe: counting started or count rewritten |
| periodic_i | input | 1 | Mode: 1 periodic, 0 one-shot |
| valset_set_i | input | 1 | Strobe arming the value-set flag |
| cmp_wr_i | input | 1 | Comparator write strobe |
| cmp_wdata_i | input | 32 | Comparator write data |
| cmp_wmask_i | input | 32 | Bit mask for the comparator write |
| fire_o | output | 1 | Single-cycle deadline strobe |
| cmp_o | output | 32 | Current deadline |
| rate_o | output | 32 | Current period (0 in one-shot mode) |
| valset_o | output | 1 | Value-set flag state |

## Verification
The hardest situation to create is a count that reaches the old deadline while a recomputation is still in flight. The stimulus holds the count still, pulses restart, and then drives the count straight onto the stale deadline during the divider's busy window. It then checks both the missing fire and the deadline that is finally loaded. Deadline arithmetic is exercised with random deadlines, periods and counts from a fixed seed, including a directed case across the 2^32 wrap. One-shot wrap firing is reached by ramping the count through 0xFFFFFFFF.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int TMR_W = 32;
    localparam int CNT_W = $clog2(TMR_W);

    typedef logic [TMR_W-1:0] word_t;

    typedef struct packed {
        word_t cmp;
        word_t rate;
        word_t base;
        logic  valset;
        logic  calc;
    } chan_st_t;

    typedef struct packed {
        word_t             rem;
        word_t             dvd;
        word_t             dsr;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              done;
    } div_st_t;

    typedef struct packed {
        logic seen;
        logic fire;
    } match_st_t;
endpackage

// File: rtl/tmr_remdiv.sv
module tmr_remdiv
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  word_t dividend_i,
    input  word_t divisor_i,
    output logic  done_o,
    output word_t rem_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMR_W - 1);

    div_st_t d, q;
    logic [TMR_W:0] trial;
    logic [TMR_W:0] diff;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.dvd[TMR_W-1]};
        diff   = trial - {1'b0, q.dsr};
        if (start_i) begin
            d.rem  = '0;
            d.dvd  = dividend_i;
            d.dsr  = divisor_i;
            d.cnt  = '0;
            d.busy = 1'b1;
        end else if (q.busy) begin
            d.rem = (trial >= {1'b0, q.dsr}) ? diff[TMR_W-1:0] : trial[TMR_W-1:0];
            d.dvd = q.dvd << 1;
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign rem_o  = q.rem;
endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t count_i,
    input  word_t cmp_i,
    input  logic  en_i,
    input  logic  hold_i,
    output logic  hit_o,
    output logic  fire_o
);
    match_st_t d, q;
    logic eq;

    always_comb begin
        eq     = en_i && (count_i == cmp_i);
        hit_o  = eq && !hold_i && !q.seen;
        d.seen = eq;
        d.fire = hit_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fire_o = q.fire;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  count_i,
    input  logic              count_en_i,
    input  logic              restart_i,
    input  logic              periodic_i,
    input  logic              valset_set_i,
    input  logic              cmp_wr_i,
    input  logic [TMR_W-1:0]  cmp_wdata_i,
    input  logic [TMR_W-1:0]  cmp_wmask_i,
    output logic              fire_o,
    output logic [TMR_W-1:0]  cmp_o,
    output logic [TMR_W-1:0]  rate_o,
    output logic              valset_o
);
    localparam chan_st_t RST = '{cmp: '1, rate: '0, base: '0, valset: 1'b0, calc: 1'b0};

    chan_st_t d, q;
    logic  calc_w;
    logic  hit;
    logic  div_start;
    word_t div_dvd;
    logic  div_done;
    word_t div_rem;
    word_t merged;
    logic  want_calc;

    assign calc_w = q.calc;

    tmr_match u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (count_i),
        .cmp_i   (q.cmp),
        .en_i    (count_en_i),
        .hold_i  (q.calc),
        .hit_o   (hit),
        .fire_o  (fire_o)
    );

    tmr_remdiv u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_dvd),
        .divisor_i  (d.rate),
        .done_o     (div_done),
        .rem_o      (div_rem)
    );

    always_comb begin
        d         = q;
        merged    = '0;
        want_calc = 1'b0;
        div_start = 1'b0;
        div_dvd   = '0;

        if (!periodic_i) begin
            d.rate = '0;
            d.calc = 1'b0;
        end
        if (valset_set_i) d.valset = 1'b1;

        // deadline = base - ((base - cmp) mod rate) + rate
        if (div_done && q.calc && periodic_i) begin
            d.cmp  = q.base - div_rem + q.rate;
            d.calc = 1'b0;
        end

        if (cmp_wr_i) begin
            if (periodic_i) begin
                merged = (q.rate & ~cmp_wmask_i) | (cmp_wdata_i & cmp_wmask_i);
                d.rate = merged;
                if (q.valset) d.cmp = merged;
            end else begin
                d.cmp = (q.cmp & ~cmp_wmask_i) | (cmp_wdata_i & cmp_wmask_i);
            end
            d.valset  = 1'b0;
            want_calc = count_en_i && ((d.cmp != q.cmp) || (d.rate != q.rate));
        end else if (restart_i || hit) begin
            want_calc = 1'b1;
        end

        if (want_calc && periodic_i && (d.rate != '0)) begin
            div_start = 1'b1;
            div_dvd   = count_i - d.cmp;
            d.base    = count_i;
            d.calc    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign cmp_o    = q.cmp;
    assign rate_o   = q.rate;
    assign valset_o = q.valset;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  count_en_i,
    input logic  periodic_i,
    input logic  cmp_wr_i,
    input logic  fire_o,
    input word_t cmp_o,
    input word_t rate_o,
    input logic  valset_o,
    input logic  calc_i
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cmp_o == '1 && rate_o == '0 && !valset_o && !fire_o));

    assert_fire_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    assert_deadline_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_i && periodic_i && !valset_o && !calc_i) |=> $stable(cmp_o));

    assert_valset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr_i |=> !valset_o);

    assert_rate_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !periodic_i |=> (rate_o == '0));

    assert_no_rearm_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_i && !count_en_i && !calc_i) |=> !calc_i);

    assert_hold_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        calc_i |=> !fire_o);
endmodule

bind tmr_channel tmr_channel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_en_i (count_en_i),
    .periodic_i (periodic_i),
    .cmp_wr_i   (cmp_wr_i),
    .fire_o     (fire_o),
    .cmp_o      (cmp_o),
    .rate_o     (rate_o),
    .valset_o   (valset_o),
    .calc_i     (calc_w)
);

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] count;
    logic        en, restart, periodic, vset, wr;
    logic [31:0] wdata, wmask;
    logic        fire;
    logic [31:0] cmp, rate;
    logic        valset;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmr_channel dut (
        .clk(clk), .rst_n(rst_n), .count_i(count), .count_en_i(en),
        .restart_i(restart), .periodic_i(periodic), .valset_set_i(vset),
        .cmp_wr_i(wr), .cmp_wdata_i(wdata), .cmp_wmask_i(wmask),
        .fire_o(fire), .cmp_o(cmp), .rate_o(rate), .valset_o(valset)
    );

    function automatic logic [31:0] next_dl(input logic [31:0] c, input logic [31:0] cv,
                                            input logic [31:0] r);
        return cv + ((c - cv) / r + 32'd1) * r;
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmp(input logic [31:0] data, input logic [31:0] mask);
        wr = 1'b1; wdata = data; wmask = mask;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic arm_valset();
        vset = 1'b1;
        @(negedge clk);
        vset = 1'b0;
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic ramp(input logic [31:0] start, input int len, input logic [31:0] e0,
                        input logic [31:0] e1, input string tag);
        for (int i = 0; i < len; i++) begin
            logic [31:0] c;
            c = start + 32'(i);
            count = c;
            @(negedge clk);
            check_eq(tag, {31'b0, fire}, {31'b0, (c == e0) || (c == e1)});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r1, r2, c, seed_val;
        rst_n = 1'b0; count = '0; en = 1'b0; restart = 1'b0; periodic = 1'b0;
        vset = 1'b0; wr = 1'b0; wdata = '0; wmask = '0;
        seed_val = $urandom(32'd1234);
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 cmp", cmp, 32'hFFFFFFFF);
        check_eq("R1 rate", rate, 32'd0);
        check_eq("R1 valset", {31'b0, valset}, 32'd0);
        check_eq("R1 fire", {31'b0, fire}, 32'd0);

        // R3 one-shot writes
        write_cmp(32'd100, 32'hFFFFFFFF);
        check_eq("R3 cmp", cmp, 32'd100);
        check_eq("R3 rate", rate, 32'd0);
        write_cmp(32'hABCD0000, 32'hFFFF0000);
        check_eq("R3 masked", cmp, 32'hABCD0064);
        write_cmp(32'd100, 32'hFFFFFFFF);

        // R2 fire once per arrival, gated by enable
        en = 1'b1;
        ramp(32'd90, 20, 32'd100, 32'd100, "R2 ramp");
        ramp(32'd99, 2, 32'd100, 32'd100, "R2 arrive");
        ramp(32'd100, 1, 32'd0, 32'd0, "R2 stall");
        ramp(32'd100, 1, 32'd0, 32'd0, "R2 stall");
        en = 1'b0;
        ramp(32'd101, 1, 32'd0, 32'd0, "R2 disabled");
        ramp(32'd100, 1, 32'd0, 32'd0, "R2 disabled");

        // R11 pending fire survives enable dropping
        write_cmp(32'd70, 32'hFFFFFFFF);
        en = 1'b1;
        ramp(32'd69, 1, 32'd0, 32'd0, "R11 before");
        count = 32'd70;
        @(posedge clk);
        #2 en = 1'b0;
        @(negedge clk);
        check_eq("R11 fire", {31'b0, fire}, 32'd1);
        @(negedge clk);
        check_eq("R11 once", {31'b0, fire}, 32'd0);

        // R10 one-shot deadline in the past waits for wrap
        write_cmp(32'd50, 32'hFFFFFFFF);
        en = 1'b1;
        ramp(32'd100, 20, 32'd0, 32'd0, "R10 past");
        ramp(32'hFFFFFFF0, 100, 32'd50, 32'd50, "R10 wrap");

        // Periodic writes: R4 R5 R9
        en = 1'b0;
        periodic = 1'b1;
        @(negedge clk);
        arm_valset();
        check_eq("R5 armed", {31'b0, valset}, 32'd1);
        write_cmp(32'd200, 32'hFFFFFFFF);
        check_eq("R4 cmp set", cmp, 32'd200);
        check_eq("R4 rate set", rate, 32'd200);
        check_eq("R5 cleared", {31'b0, valset}, 32'd0);
        write_cmp(32'd300, 32'hFFFFFFFF);
        check_eq("R4 cmp kept", cmp, 32'd200);
        check_eq("R4 rate only", rate, 32'd300);
        write_cmp(32'h00000001, 32'h0000FF00);
        check_eq("R4 masked rate", rate, 32'h0000002C);
        write_cmp(32'd300, 32'hFFFFFFFF);
        idle(40);
        check_eq("R9 idle no rearm", cmp, 32'd200);

        // R7 periodic advance
        en = 1'b1;
        ramp(32'd150, 400, 32'd200, 32'd500, "R7 fires");
        check_eq("R7 next", cmp, 32'd800);

        // R8 restart rounding
        count = 32'd1000;
        pulse_restart();
        idle(40);
        check_eq("R8 restart", cmp, next_dl(32'd1000, 32'd800, 32'd300));

        // R9 rearm on rate change while enabled
        count = 32'd5000;
        write_cmp(32'd400, 32'hFFFFFFFF);
        idle(40);
        check_eq("R9 rearm", cmp, next_dl(32'd5000, 32'd1100, 32'd400));

        // R12 suppression during recomputation
        count = 32'd5300;
        pulse_restart();
        for (int k = 0; k < 5; k++) ramp(32'd5100, 1, 32'd0, 32'd0, "R12 hold");
        count = 32'd5101;
        idle(40);
        check_eq("R12 result", cmp, next_dl(32'd5300, 32'd5100, 32'd400));

        // R8 across the wrap
        en = 1'b0;
        arm_valset();
        write_cmp(32'hFFFFFF00, 32'hFFFFFFFF);
        write_cmp(32'h00000200, 32'hFFFFFFFF);
        count = 32'hFFFFFFF0;
        en = 1'b1;
        pulse_restart();
        idle(40);
        check_eq("R8 wrap", cmp, 32'h00000100);

        // R8 random deadlines, periods and counts
        for (int n = 0; n < 20; n++) begin
            en = 1'b0;
            r1 = $urandom;
            r2 = 32'd64 + $urandom_range(0, 100000);
            c  = $urandom;
            if (c == r1) c = c + 32'd1;
            arm_valset();
            write_cmp(r1, 32'hFFFFFFFF);
            write_cmp(r2, 32'hFFFFFFFF);
            count = c;
            en = 1'b1;
            pulse_restart();
            idle(40);
            check_eq("R8 random", cmp, next_dl(c, r1, r2));
        end
        en = 1'b0;

        // R6 leaving periodic mode zeroes the rate
        periodic = 1'b0;
        @(negedge clk);
        check_eq("R6 zero", rate, 32'd0);
        periodic = 1'b1;
        @(negedge clk);
        check_eq("R6 stays", rate, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule